// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits behind an instruction fetch unit and turns a little-endian byte stream into decoded instruction records. Bytes arrive one per cycle over a valid/ready handshake. The first byte of each instruction selects one of three layouts. A register form is 4 bytes long and carries four register nibbles. A jump form is 4 bytes long and carries a 16-bit offset. An immediate form is 4 header bytes followed by a little-endian immediate.

When the final byte of an instruction is accepted, the block emits one record. The record holds the opcode, the operand-length code, the layout, the register numbers, the flags byte, the offset, the immediate and the total length. The fetch pointer uses that length to advance.

Two kinds of header byte are illegal: an opcode value that is not assigned, and a floating-point opcode paired with a 2-byte or 1-byte operand length. Either one stops the decoder with a halt and a cause code. The halt holds until reset. Break and breakpoint opcodes are decoded normally and are marked in the record, so the execution stage can trap on them.

Top module: `ivd_decoder`

## Requirements
- R1: The opcode is bits 7:2 of the first byte and the operand-length code (00 = 8 bytes, 01 = 4, 10 = 2, 11 = 1) is bits 1:0. Both are reported unchanged in the record.
- R2: The layout code and length are chosen by opcode:
  - opcodes 13, 14, 39 and 40 give layout 01 (jump) with length 4;
  - opcodes 3, 5, 6, 8 and 45 give layout 10 (immediate) with length 4+IMM_BYTES;
  - every other legal opcode gives layout 00 (register) with length 4.
- R3: In the register layout, reg0 is byte 1 bits 3:0, reg1 is byte 1 bits 7:4, reg2 is byte 2 bits 3:0, reg3 is byte 2 bits 7:4 and the flags are byte 3. The offset and the immediate read zero.
- R4: In the jump layout, the offset is {byte 2, byte 1} and the flags are byte 3. All four register fields and the immediate read zero.
- R5: In the immediate layout, the register fields and flags are taken as in R3, and the immediate is bytes 4 upward with byte 4 as the least significant byte. The offset reads zero.
- R6: rec_valid is high for exactly one cycle: the cycle after the final byte of an instruction is accepted. The first byte of the next instruction may be accepted in that same cycle.
- R7: A byte is consumed only in a cycle where in_valid and in_ready are both high. Idle cycles between bytes do not change the decoded result.
- R8: A first byte with opcode 25 to 29 or 31 and operand-length code 10 or 11 raises halt with cause 10, one cycle after it is accepted, and produces no record. With code 00 or 01 these opcodes decode as register layout.
- R9: A first byte with an unassigned opcode (47 to 62) raises halt with cause 01, one cycle after it is accepted, and produces no record. Opcode 46 is legal.
- R10: Once halt is high it stays high, in_ready stays low and no record is produced, whatever is driven on the input, until reset.
- R11: Opcodes 0, 1 and 63 decode as register layout with rec_brk high and raise no halt. rec_brk is low for every other opcode.
- R12: After reset, in_ready is 1 and rec_valid, halt and halt_cause are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Decoder can take a byte |
| rec_valid | output | 1 | Decoded record valid (one-cycle pulse) |
| rec_opcode | output | 6 | Opcode |
| rec_oplen | output | 2 | Operand-length code |
| rec_fmt | output | 2 | Layout: 00 register, 01 jump, 10 immediate |
| rec_reg0 | output | 4 | Register field 0 |
| rec_reg1 | output | 4 | Register field 1 |
| rec_reg2 | output | 4 | Register field 2 |
| rec_reg3 | output | 4 | Register field 3 |
| rec_flags | output | 8 | Flags / condition byte |
| rec_offset | output | 16 | Branch offset (jump layout) |
| rec_imm | output | 8*IMM_BYTES | Immediate (immediate layout) |
| rec_len | output | $clog2(5+IMM_BYTES) | Instruction length in bytes |
| rec_brk | output | 1 | Break or breakpoint opcode |
| halt | output | 1 | Sticky halt |
| halt_cause | output | 2 | 01 unassigned opcode, 10 bad floating-point operand length |

## Verification
The bench builds the decoder with the default IMM_BYTES of 8. This gives 12-byte immediate instructions and a 4-bit length field. It therefore reaches the highest byte-slot index of the collect buffer and exercises the full placement of a 64-bit little-endian immediate. With these settings, a register instruction followed directly by another one shows the one-cycle record pulse overlapping acceptance of the next first byte. The boundary opcodes 46, 47, 62 and 63 sit at the edges of the unassigned range.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

    localparam int HDR_BYTES = 4;

    typedef enum logic [1:0] {
        FMT_REG  = 2'd0,
        FMT_JUMP = 2'd1,
        FMT_LONG = 2'd2
    } ifmt_e;

    typedef enum logic [1:0] {
        HC_NONE       = 2'd0,
        HC_UNASSIGNED = 2'd1,
        HC_FP_LEN     = 2'd2
    } hcause_e;

    localparam logic [5:0] OP_HIGHEST_LEGAL = 6'd46;
    localparam logic [5:0] OP_BREAKPOINT    = 6'd63;

    typedef struct packed {
        logic [5:0]  opcode;
        logic [1:0]  oplen;
        ifmt_e       fmt;
        logic [3:0]  r0;
        logic [3:0]  r1;
        logic [3:0]  r2;
        logic [3:0]  r3;
        logic [7:0]  flags;
        logic [15:0] offset;
        logic        brk;
    } ihdr_t;

    function automatic logic [5:0] op_of(input logic [7:0] b);
        return b[7:2];
    endfunction

    function automatic ifmt_e fmt_of(input logic [5:0] op);
        case (op)
            6'd13, 6'd14, 6'd39, 6'd40:       return FMT_JUMP;
            6'd3, 6'd5, 6'd6, 6'd8, 6'd45:     return FMT_LONG;
            default:                           return FMT_REG;
        endcase
    endfunction

    function automatic logic is_fp(input logic [5:0] op);
        return (op >= 6'd25 && op <= 6'd29) || op == 6'd31;
    endfunction

    function automatic logic is_assigned(input logic [5:0] op);
        return (op <= OP_HIGHEST_LEGAL) || (op == OP_BREAKPOINT);
    endfunction

    function automatic logic is_break(input logic [5:0] op);
        return (op == 6'd0) || (op == 6'd1) || (op == OP_BREAKPOINT);
    endfunction

endpackage

// File: rtl/ivd_classify.sv
module ivd_classify
    import ivd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    localparam int LONG_LEN = HDR_BYTES + IMM_BYTES,
    localparam int LW = $clog2(LONG_LEN + 1)
) (
    input  logic [7:0]    hdr_byte,
    output logic [LW-1:0] hdr_len,
    output hcause_e       cause
);

    logic [5:0] op;
    ifmt_e      fmt;

    always_comb begin
        op  = op_of(hdr_byte);
        fmt = fmt_of(op);
        hdr_len = (fmt == FMT_LONG) ? LW'(LONG_LEN) : LW'(HDR_BYTES);
        if (!is_assigned(op))
            cause = HC_UNASSIGNED;
        else if (is_fp(op) && hdr_byte[1])
            cause = HC_FP_LEN;
        else
            cause = HC_NONE;
    end

endmodule

// File: rtl/ivd_collect.sv
module ivd_collect
    import ivd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    localparam int LONG_LEN = HDR_BYTES + IMM_BYTES,
    localparam int LW = $clog2(LONG_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc,
    input  logic [7:0]            in_byte,
    input  logic                  abort,
    input  logic [LW-1:0]         head_len,
    output logic                  at_head,
    output logic                  last,
    output logic [LW-1:0]         cur_len,
    output logic [LONG_LEN*8-1:0] buf_next
);

    logic [LW-1:0]         cnt_q;
    logic [LW-1:0]         len_q;
    logic [LONG_LEN*8-1:0] buf_q;

    assign at_head = (cnt_q == '0);
    assign cur_len = at_head ? head_len : len_q;
    assign last    = acc && !abort && (cnt_q == cur_len - 1'b1);

    for (genvar i = 0; i < LONG_LEN; i++) begin : g_slot
        assign buf_next[i*8 +: 8] = (acc && cnt_q == LW'(i)) ? in_byte : buf_q[i*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            len_q <= LW'(HDR_BYTES);
            buf_q <= '0;
        end else if (acc) begin
            buf_q <= buf_next;
            if (abort || last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (at_head) begin
                len_q <= head_len;
            end
        end
    end

endmodule

// File: rtl/ivd_format.sv
module ivd_format
    import ivd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    localparam int LONG_LEN = HDR_BYTES + IMM_BYTES
) (
    input  logic [LONG_LEN*8-1:0]  bytes,
    output ihdr_t                  hdr,
    output logic [IMM_BYTES*8-1:0] imm
);

    logic [7:0] b0, b1, b2, b3;
    ifmt_e      fmt;

    assign b0  = bytes[7:0];
    assign b1  = bytes[15:8];
    assign b2  = bytes[23:16];
    assign b3  = bytes[31:24];
    assign fmt = fmt_of(op_of(b0));

    always_comb begin
        hdr.opcode = op_of(b0);
        hdr.oplen  = b0[1:0];
        hdr.fmt    = fmt;
        hdr.flags  = b3;
        hdr.brk    = is_break(op_of(b0));
        if (fmt == FMT_JUMP) begin
            hdr.r0     = '0;
            hdr.r1     = '0;
            hdr.r2     = '0;
            hdr.r3     = '0;
            hdr.offset = {b2, b1};
        end else begin
            hdr.r0     = b1[3:0];
            hdr.r1     = b1[7:4];
            hdr.r2     = b2[3:0];
            hdr.r3     = b2[7:4];
            hdr.offset = '0;
        end
    end

    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm
        assign imm[k*8 +: 8] = (fmt == FMT_LONG) ? bytes[(HDR_BYTES+k)*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/ivd_decoder.sv
module ivd_decoder
    import ivd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    localparam int LONG_LEN = HDR_BYTES + IMM_BYTES,
    localparam int LW = $clog2(LONG_LEN + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   in_ready,
    output logic                   rec_valid,
    output logic [5:0]             rec_opcode,
    output logic [1:0]             rec_oplen,
    output logic [1:0]             rec_fmt,
    output logic [3:0]             rec_reg0,
    output logic [3:0]             rec_reg1,
    output logic [3:0]             rec_reg2,
    output logic [3:0]             rec_reg3,
    output logic [7:0]             rec_flags,
    output logic [15:0]            rec_offset,
    output logic [IMM_BYTES*8-1:0] rec_imm,
    output logic [LW-1:0]          rec_len,
    output logic                   rec_brk,
    output logic                   halt,
    output logic [1:0]             halt_cause
);

    logic                  acc;
    logic [LW-1:0]         cls_len;
    hcause_e               cls_cause;
    logic                  at_head;
    logic                  abort;
    logic                  last;
    logic [LW-1:0]         cur_len;
    logic [LONG_LEN*8-1:0] buf_next;
    ihdr_t                 f_hdr;
    logic [IMM_BYTES*8-1:0] f_imm;

    logic                  halt_q;
    hcause_e               cause_q;
    logic                  rv_q;
    ihdr_t                 hdr_q;
    logic [IMM_BYTES*8-1:0] imm_q;
    logic [LW-1:0]         len_q;

    assign in_ready = !halt_q;
    assign acc      = in_valid && in_ready;
    assign abort    = at_head && (cls_cause != HC_NONE);

    ivd_classify #(.IMM_BYTES(IMM_BYTES)) u_cls (
        .hdr_byte (in_byte),
        .hdr_len  (cls_len),
        .cause    (cls_cause)
    );

    ivd_collect #(.IMM_BYTES(IMM_BYTES)) u_col (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .in_byte  (in_byte),
        .abort    (abort),
        .head_len (cls_len),
        .at_head  (at_head),
        .last     (last),
        .cur_len  (cur_len),
        .buf_next (buf_next)
    );

    ivd_format #(.IMM_BYTES(IMM_BYTES)) u_fmt (
        .bytes (buf_next),
        .hdr   (f_hdr),
        .imm   (f_imm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q  <= 1'b0;
            cause_q <= HC_NONE;
            rv_q    <= 1'b0;
            hdr_q   <= '0;
            imm_q   <= '0;
            len_q   <= '0;
        end else begin
            rv_q <= last;
            if (last) begin
                hdr_q <= f_hdr;
                imm_q <= f_imm;
                len_q <= cur_len;
            end
            if (acc && abort) begin
                halt_q  <= 1'b1;
                cause_q <= cls_cause;
            end
        end
    end

    assign rec_valid  = rv_q;
    assign rec_opcode = hdr_q.opcode;
    assign rec_oplen  = hdr_q.oplen;
    assign rec_fmt    = hdr_q.fmt;
    assign rec_reg0   = hdr_q.r0;
    assign rec_reg1   = hdr_q.r1;
    assign rec_reg2   = hdr_q.r2;
    assign rec_reg3   = hdr_q.r3;
    assign rec_flags  = hdr_q.flags;
    assign rec_offset = hdr_q.offset;
    assign rec_brk    = hdr_q.brk;
    assign rec_imm    = imm_q;
    assign rec_len    = len_q;
    assign halt       = halt_q;
    assign halt_cause = cause_q;

endmodule

// File: rtl/ivd_decoder_chk.sv
module ivd_decoder_chk
    import ivd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    localparam int LONG_LEN = HDR_BYTES + IMM_BYTES,
    localparam int LW = $clog2(LONG_LEN + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          rec_valid,
    input logic [5:0]    rec_opcode,
    input logic [1:0]    rec_oplen,
    input logic [1:0]    rec_fmt,
    input logic [3:0]    rec_reg0,
    input logic [3:0]    rec_reg1,
    input logic [3:0]    rec_reg2,
    input logic [3:0]    rec_reg3,
    input logic [LW-1:0] rec_len,
    input logic          halt
);

    logic [LW:0] acc_since;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_since <= '0;
        end else if (rec_valid) begin
            acc_since <= (in_valid && in_ready) ? (LW+1)'(1) : '0;
        end else if (in_valid && in_ready) begin
            acc_since <= acc_since + 1'b1;
        end
    end

    AST_REC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rec_valid |=> !rec_valid); // R6

    AST_LEN_MATCHES_BYTES: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (acc_since == (LW+1)'(rec_len))); // R2

    AST_LONG_LEN: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> ((rec_fmt == 2'd2) == (rec_len == LW'(LONG_LEN)))); // R2

    AST_JUMP_NO_REGS: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_fmt == 2'd1) |-> (rec_reg0 == 4'd0 && rec_reg1 == 4'd0
                                            && rec_reg2 == 4'd0 && rec_reg3 == 4'd0)); // R4

    AST_FP_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && is_fp(rec_opcode)) |-> !rec_oplen[1]); // R8

    AST_OPCODE_ASSIGNED: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> is_assigned(rec_opcode)); // R9

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt); // R10

    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        halt |-> (!in_ready && !rec_valid)); // R10

endmodule

bind ivd_decoder ivd_decoder_chk #(.IMM_BYTES(IMM_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .rec_valid  (rec_valid),
    .rec_opcode (rec_opcode),
    .rec_oplen  (rec_oplen),
    .rec_fmt    (rec_fmt),
    .rec_reg0   (rec_reg0),
    .rec_reg1   (rec_reg1),
    .rec_reg2   (rec_reg2),
    .rec_reg3   (rec_reg3),
    .rec_len    (rec_len),
    .halt       (halt)
);

// File: tb/ivd_decoder_test.sv
`timescale 1ns/1ps
module ivd_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, rec_valid, rec_brk, halt;
    logic [5:0]  rec_opcode;
    logic [1:0]  rec_oplen, rec_fmt, halt_cause;
    logic [3:0]  rec_reg0, rec_reg1, rec_reg2, rec_reg3;
    logic [7:0]  rec_flags;
    logic [15:0] rec_offset;
    logic [63:0] rec_imm;
    logic [3:0]  rec_len;

    int checks = 0;
    int errors = 0;
    logic [7:0] q [16];

    always #2 clk = ~clk;

    ivd_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rec_valid(rec_valid), .rec_opcode(rec_opcode),
        .rec_oplen(rec_oplen), .rec_fmt(rec_fmt), .rec_reg0(rec_reg0),
        .rec_reg1(rec_reg1), .rec_reg2(rec_reg2), .rec_reg3(rec_reg3),
        .rec_flags(rec_flags), .rec_offset(rec_offset), .rec_imm(rec_imm),
        .rec_len(rec_len), .rec_brk(rec_brk), .halt(halt), .halt_cause(halt_cause)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = q[i];
            @(posedge clk);
            if (gap > 0 && i < n - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_rec(string req, logic [5:0] op, logic [1:0] ol, logic [1:0] fmt,
                              logic [15:0] regs, logic [7:0] fl, logic [15:0] off,
                              logic [63:0] imm, logic [3:0] len, logic brk);
        check({req, " valid"}, rec_valid, 1);
        check({req, " opcode R1"}, rec_opcode, op);
        check({req, " oplen R1"}, rec_oplen, ol);
        check({req, " fmt R2"}, rec_fmt, fmt);
        check({req, " len R2"}, rec_len, len);
        check({req, " regs"}, {rec_reg3, rec_reg2, rec_reg1, rec_reg0}, regs);
        check({req, " flags"}, rec_flags, fl);
        check({req, " offset"}, rec_offset, off);
        check({req, " imm"}, rec_imm, imm);
        check({req, " brk R11"}, rec_brk, brk);
        check({req, " no halt"}, halt, 0);
        @(negedge clk);
        check({req, " pulse R6"}, rec_valid, 0);
    endtask

    task automatic t_reset_state();
        check("R12 ready", in_ready, 1);
        check("R12 rec_valid", rec_valid, 0);
        check("R12 halt", halt, 0);
        check("R12 cause", halt_cause, 0);
    endtask

    task automatic t_register_form();
        q[0] = 8'h3D; q[1] = 8'hA5; q[2] = 8'h3C; q[3] = 8'h7E;
        send(4, 0);
        expect_rec("R3 add", 6'd15, 2'b01, 2'd0, 16'h3CA5, 8'h7E, 16'h0, 64'h0, 4'd4, 1'b0);
    endtask

    task automatic t_jump_forms();
        q[0] = 8'h37; q[1] = 8'h34; q[2] = 8'h12; q[3] = 8'h90;
        send(4, 0);
        expect_rec("R4 b", 6'd13, 2'b11, 2'd1, 16'h0, 8'h90, 16'h1234, 64'h0, 4'd4, 1'b0);
        q[0] = 8'hA0; q[1] = 8'hFE; q[2] = 8'hFF; q[3] = 8'h22;
        send(4, 0);
        expect_rec("R4 ccall", 6'd40, 2'b00, 2'd1, 16'h0, 8'h22, 16'hFFFE, 64'h0, 4'd4, 1'b0);
    endtask

    task automatic t_long_forms();
        q[0] = 8'h0E; q[1] = 8'h21; q[2] = 8'h43; q[3] = 8'h01;
        for (int k = 0; k < 8; k++) q[4+k] = 8'h88 - 8'h11 * k[7:0];
        send(12, 0);
        expect_rec("R5 load_imm", 6'd3, 2'b10, 2'd2, 16'h4321, 8'h01, 16'h0,
                   64'h1122334455667788, 4'd12, 1'b0);
        q[0] = 8'hB4; q[1] = 8'h00; q[2] = 8'h00; q[3] = 8'h00;
        for (int k = 0; k < 8; k++) q[4+k] = 8'hF0 | k[7:0];
        send(12, 2);
        expect_rec("R7 gaps native", 6'd45, 2'b00, 2'd2, 16'h0, 8'h00, 16'h0,
                   64'hF7F6F5F4F3F2F1F0, 4'd12, 1'b0);
    endtask

    task automatic t_back_to_back();
        q[0] = 8'h24; q[1] = 8'h10; q[2] = 8'h00; q[3] = 8'h00;
        q[4] = 8'hB8; q[5] = 8'h9F; q[6] = 8'hED; q[7] = 8'h55;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 4) begin
                check("R6 first rec", rec_valid, 1);
                check("R6 first opcode", rec_opcode, 6'd9);
            end else if (i == 5) begin
                check("R6 first pulse ends", rec_valid, 0);
            end
            in_valid = 1'b1; in_byte = q[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        expect_rec("R9 op46 legal", 6'd46, 2'b00, 2'd0, 16'hED9F, 8'h55, 16'h0, 64'h0, 4'd4, 1'b0);
    endtask

    task automatic t_fp_legal_and_breaks();
        q[0] = 8'h65; q[1] = 8'h21; q[2] = 8'h00; q[3] = 8'h00;
        send(4, 0);
        expect_rec("R8 fadd dword", 6'd25, 2'b01, 2'd0, 16'h0021, 8'h00, 16'h0, 64'h0, 4'd4, 1'b0);
        q[0] = 8'hFC; q[1] = 8'h00; q[2] = 8'h00; q[3] = 8'h00;
        send(4, 0);
        expect_rec("R11 breakpoint", 6'd63, 2'b00, 2'd0, 16'h0, 8'h00, 16'h0, 64'h0, 4'd4, 1'b1);
        q[0] = 8'h04; q[1] = 8'h00; q[2] = 8'h00; q[3] = 8'h81;
        send(4, 0);
        expect_rec("R11 cbrk", 6'd1, 2'b00, 2'd0, 16'h0, 8'h81, 16'h0, 64'h0, 4'd4, 1'b1);
    endtask

    task automatic t_halt(string req, logic [7:0] b0, logic [1:0] cause);
        do_reset();
        q[0] = b0;
        send(1, 0);
        check({req, " halt"}, halt, 1);
        check({req, " cause"}, halt_cause, cause);
        check({req, " no rec"}, rec_valid, 0);
        check("R10 ready low", in_ready, 0);
        q[0] = 8'h3D; q[1] = 8'hA5; q[2] = 8'h3C; q[3] = 8'h7E;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = q[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 still halted", halt, 1);
        check("R10 no record", rec_valid, 0);
        check("R10 cause kept", halt_cause, cause);
        do_reset();
        check("R12 halt cleared", halt, 0);
        send(4, 0);
        expect_rec("R10 resume", 6'd15, 2'b01, 2'd0, 16'h3CA5, 8'h7E, 16'h0, 64'h0, 4'd4, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_register_form();
        t_jump_forms();
        t_long_forms();
        t_back_to_back();
        t_fp_legal_and_breaks();
        t_halt("R8 fmul word", 8'h6E, 2'b10);
        t_halt("R8 fneg byte", 8'h7F, 2'b10);
        t_halt("R9 op47", 8'hBC, 2'b01);
        t_halt("R9 op62", 8'hF8, 2'b01);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule